// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the standard 64-byte type-0 configuration header of one device function. A single access port presents a byte offset, an access width of 1, 2 or 4 bytes, a write strobe and right-justified write data. Read data comes back combinationally in the same cycle. Writes commit on the next rising clock edge. Any access the header does not support raises an error flag in that same cycle, and an erroring write changes nothing.

Six base address registers support the usual discovery sequence. Software writes all ones, reads back a size mask, and then programs a base. For each BAR the block drives a decoded base, aligned to the BAR's size, together with a valid bit, so that the surrounding address decoder can claim the window. Identity fields, the interrupt pin, the BAR reset contents and the BAR sizes are all parameters. The expansion ROM base register has its own sizing reply.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset, a dword read at 0x00 returns {DEVICE_ID, VENDOR_ID}, at 0x08 returns {CLASS_CODE, REVISION}, and at 0x3C returns {8'h00, 8'h00, INT_PIN, 8'h00}. Header type (0x0E) reads 0.
- R2: A read returns acc_size bytes starting at acc_off, little-endian (the lowest offset is bit 7:0), zero-extended to 32 bits.
- R3: acc_err rises in the access cycle for any of these: size not 1, 2 or 4; a 2-byte access at an odd offset; a 4-byte access whose offset is not a multiple of 4; offset 0x40 or above. An erroring access changes no state, and its read data is 0.
- R4: Byte writes to 0x0C (cache line size), 0x0D (latency timer) and 0x3C (interrupt line) store the low data byte.
- R5: Byte writes to 0x08–0x0B and 0x3D–0x3F are ignored without an error.
- R6: A byte write to any other offset below 0x40 raises acc_err.
- R7: The command register (0x04, bits 15:0) is written by a 2-byte access at 0x04, or by the low half of a 4-byte access there. A 2-byte write at 0x06 is ignored. A 2-byte write at 0x0C writes the cache line size from the low byte. Other 2-byte writes raise acc_err. 4-byte writes to offsets other than a BAR, the ROM base or 0x04 are ignored without an error.
- R8: BAR i sits at 0x10+4i. Its type mask is 0x3 when the stored bit 0 is 1 (I/O) and 0xF otherwise (memory). A 4-byte write of 0xFFFFFFFF loads ~(size-1) with the type-mask bits cleared, ORed with the existing type bits.
- R9: Any other 4-byte BAR write stores the write data with the type-mask bits cleared and keeps the existing type bits.
- R10: After a non-sizing BAR write whose data has nonzero bits outside the type mask, bar_base[32i+31:32i] takes data & ~mask & ~(size-1) and bar_valid[i] is set. Otherwise base and valid are unchanged. valid never clears outside reset.
- R11: A BAR whose size parameter is 0 always reads 0 and is never valid.
- R12: A 4-byte write of 0xFFFFFFFE to the ROM base (0x30) makes it read 0xFFFFFFFF. Any other 4-byte value is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset |
| acc_size | input | 3 | Access width in bytes |
| acc_wdata | input | 32 | Right-justified write data |
| acc_rdata | output | 32 | Read data, zero-extended |
| acc_err | output | 1 | Unsupported access |
| bar_base | output | 192 | Decoded base per BAR, BAR i in bits 32i+31:32i |
| bar_valid | output | 6 | Decoded base valid per BAR |

## Verification
The bench sets up a mixed BAR set. BAR0 is a 4 KiB memory BAR with the prefetch bit set. BAR1 is a 256-byte I/O BAR. BAR2 has size 0 and a nonzero reset value. BAR3 is the minimum 16-byte memory BAR. BAR4 is the minimum 4-byte I/O BAR. BAR5 is a 1 MiB memory BAR. With this set, both type masks, the alignment of bases at both extremes and the forced-zero BAR are all reachable from random writes, including writes of all ones and of the ROM sizing value.

// File: rtl/pci_cfg_header.sv
module pci_cfg_header #(
  parameter logic [15:0]  VENDOR_ID  = 16'hCAFE,
  parameter logic [15:0]  DEVICE_ID  = 16'h0B17,
  parameter logic [23:0]  CLASS_CODE = 24'h020000,
  parameter logic [7:0]   REVISION   = 8'h01,
  parameter logic [7:0]   INT_PIN    = 8'h01,
  parameter logic [191:0] BAR_INIT   = {32'h0, 32'h1, 32'h0, 32'h0, 32'h1, 32'h8},
  parameter logic [191:0] BAR_SIZE   = {32'h100000, 32'h4, 32'h10, 32'h0, 32'h100, 32'h1000},
  parameter logic [7:0]   SPEC_BASE  = 8'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_en,
  input  logic         acc_wr,
  input  logic [7:0]   acc_off,
  input  logic [2:0]   acc_size,
  input  logic [31:0]  acc_wdata,
  output logic [31:0]  acc_rdata,
  output logic         acc_err,
  output logic [191:0] bar_base,
  output logic [5:0]   bar_valid
);
  localparam int NBAR = 6;

  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, irq_line_q;
  logic [31:0] rom_q;
  logic [191:0] bar_flat;

  wire [3:0] dw_idx = acc_off[5:2];
  wire [2:0] bsel   = 3'(dw_idx - 4'd4);

  wire sz1 = acc_size == 3'd1;
  wire sz2 = acc_size == 3'd2;
  wire sz4 = acc_size == 3'd4;
  wire bad_size = !(sz1 || sz2 || sz4);
  wire misalign = (sz2 && acc_off[0]) || (sz4 && acc_off[1:0] != 2'b00);
  wire too_high = acc_off >= SPEC_BASE;

  wire b_ok  = acc_off == 8'h0C || acc_off == 8'h0D || acc_off == 8'h3C;
  wire b_ign = (acc_off >= 8'h08 && acc_off <= 8'h0B) || (acc_off >= 8'h3D && acc_off <= 8'h3F);
  wire h_ok  = acc_off == 8'h04 || acc_off == 8'h06 || acc_off == 8'h0C;

  assign acc_err = acc_en && (bad_size || misalign || too_high ||
                   (acc_wr && sz1 && !(b_ok || b_ign)) ||
                   (acc_wr && sz2 && !h_ok));
  wire wr_ok = acc_en && acc_wr && !acc_err;

  logic [31:0] rd_dw, rd_sh;
  always_comb begin
    case (dw_idx)
      4'h0: rd_dw = {DEVICE_ID, VENDOR_ID};
      4'h1: rd_dw = {16'h0, cmd_q};
      4'h2: rd_dw = {CLASS_CODE, REVISION};
      4'h3: rd_dw = {16'h0, lat_q, cls_q};
      4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9: rd_dw = bar_flat[{bsel, 5'd0} +: 32];
      4'hC: rd_dw = rom_q;
      4'hF: rd_dw = {16'h0, INT_PIN, irq_line_q};
      default: rd_dw = 32'h0;
    endcase
    rd_sh = rd_dw >> {acc_off[1:0], 3'b000};
    if (sz1)      rd_sh = rd_sh & 32'h0000_00FF;
    else if (sz2) rd_sh = rd_sh & 32'h0000_FFFF;
  end
  assign acc_rdata = (acc_en && !acc_wr && !acc_err) ? rd_sh : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      cls_q      <= '0;
      lat_q      <= '0;
      irq_line_q <= '0;
      rom_q      <= '0;
    end else if (wr_ok) begin
      if (sz1) begin
        if (acc_off == 8'h0C) cls_q      <= acc_wdata[7:0];
        if (acc_off == 8'h0D) lat_q      <= acc_wdata[7:0];
        if (acc_off == 8'h3C) irq_line_q <= acc_wdata[7:0];
      end else if (sz2) begin
        if (acc_off == 8'h04) cmd_q <= acc_wdata[15:0];
        if (acc_off == 8'h0C) cls_q <= acc_wdata[7:0];
      end else begin
        if (acc_off == 8'h04) cmd_q <= acc_wdata[15:0];
        if (acc_off == 8'h30) rom_q <= (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;
      end
    end
  end

  for (genvar i = 0; i < NBAR; i++) begin : g_bar
    localparam logic [31:0] SZ   = BAR_SIZE[32*i +: 32];
    localparam logic [31:0] INIT = BAR_INIT[32*i +: 32];
    logic [31:0] q, base_q;
    logic        vld_q;
    if (SZ == 32'h0) begin : g_off
      assign q      = '0;
      assign base_q = '0;
      assign vld_q  = 1'b0;
    end else begin : g_on
      wire        hit   = wr_ok && sz4 && dw_idx == 4'(i + 4);
      wire [31:0] tmask = q[0] ? 32'h3 : 32'hF;
      wire [31:0] bbits = acc_wdata & ~tmask;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q      <= INIT;
          base_q <= '0;
          vld_q  <= 1'b0;
        end else if (hit) begin
          if (acc_wdata == 32'hFFFF_FFFF) begin
            q <= (~(SZ - 32'd1) & ~tmask) | (q & tmask);
          end else begin
            q <= bbits | (q & tmask);
            if (bbits != 32'h0) begin
              base_q <= bbits & ~(SZ - 32'd1);
              vld_q  <= 1'b1;
            end
          end
        end
      end
    end
    assign bar_flat[32*i +: 32] = q;
    assign bar_base[32*i +: 32] = base_q;
    assign bar_valid[i]         = vld_q;
  end
endmodule

module pci_cfg_header_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_en,
  input logic         acc_wr,
  input logic [7:0]   acc_off,
  input logic [2:0]   acc_size,
  input logic [31:0]  acc_rdata,
  input logic         acc_err,
  input logic [191:0] bar_base,
  input logic [5:0]   bar_valid
);
  AST_HIGH_OFF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_off >= 8'h40) |-> acc_err); // R3
  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_size != 3'd1 && acc_size != 3'd2 && acc_size != 3'd4) |-> acc_err); // R3
  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_err) |=> ($stable(bar_base) && $stable(bar_valid))); // R3
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_off == 8'h00 && acc_size == 3'd4) |-> acc_rdata == {DEVICE_ID, VENDOR_ID}); // R1
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(bar_valid)) & ~bar_valid) == 6'h0)); // R10
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr) |=> $stable(bar_base)); // R10
endmodule

bind pci_cfg_header pci_cfg_header_chk #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_off(acc_off),
  .acc_size(acc_size), .acc_rdata(acc_rdata), .acc_err(acc_err),
  .bar_base(bar_base), .bar_valid(bar_valid));

// File: tb/pci_cfg_header_tb.sv
`timescale 1ns/1ps
module pci_cfg_header_tb;
  localparam logic [15:0]  VID  = 16'hCAFE;
  localparam logic [15:0]  DID  = 16'h0B17;
  localparam logic [23:0]  CLS  = 24'h020000;
  localparam logic [7:0]   REV  = 8'h03;
  localparam logic [7:0]   IPIN = 8'h01;
  localparam logic [191:0] TB_INIT = {32'h0, 32'h1, 32'h0, 32'h4, 32'h1, 32'h8};
  localparam logic [191:0] TB_SIZE = {32'h100000, 32'h4, 32'h10, 32'h0, 32'h100, 32'h1000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0;
  logic [7:0] acc_off = '0;
  logic [2:0] acc_size = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic acc_err;
  logic [191:0] bar_base;
  logic [5:0] bar_valid;

  always #4 clk = ~clk;

  pci_cfg_header #(.VENDOR_ID(VID), .DEVICE_ID(DID), .CLASS_CODE(CLS), .REVISION(REV),
    .INT_PIN(IPIN), .BAR_INIT(TB_INIT), .BAR_SIZE(TB_SIZE)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_off(acc_off),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
    .bar_base(bar_base), .bar_valid(bar_valid));

  int n_vec = 0, n_bad = 0;
  logic [15:0] m_cmd;
  logic [7:0]  m_cls, m_lat, m_line;
  logic [31:0] m_rom;
  logic [31:0] m_bar [6];
  logic [31:0] m_base [6];
  logic [5:0]  m_vld;
  logic [31:0] s_rd;
  logic        s_err;

  function automatic logic [31:0] sz_of(int i);
    return TB_SIZE[32*i +: 32];
  endfunction

  task automatic model_reset();
    m_cmd = '0; m_cls = '0; m_lat = '0; m_line = '0; m_rom = '0; m_vld = '0;
    for (int i = 0; i < 6; i++) begin
      m_bar[i]  = (sz_of(i) == 0) ? 32'h0 : TB_INIT[32*i +: 32];
      m_base[i] = '0;
    end
  endtask

  function automatic bit exp_err(logic [7:0] o, logic [2:0] s, bit w);
    bit bad = !(s == 1 || s == 2 || s == 4);
    bad |= (s == 2 && o[0]) || (s == 4 && o[1:0] != 0) || o >= 8'h40;
    if (w && s == 1 && !(o == 8'h0C || o == 8'h0D || o == 8'h3C ||
        (o >= 8'h08 && o <= 8'h0B) || (o >= 8'h3D && o <= 8'h3F))) bad = 1;
    if (w && s == 2 && !(o == 8'h04 || o == 8'h06 || o == 8'h0C)) bad = 1;
    return bad;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] o, logic [2:0] s);
    logic [31:0] d;
    case (o[5:2])
      4'h0: d = {DID, VID};
      4'h1: d = {16'h0, m_cmd};
      4'h2: d = {CLS, REV};
      4'h3: d = {16'h0, m_lat, m_cls};
      4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9: d = m_bar[o[5:2] - 4];
      4'hC: d = m_rom;
      4'hF: d = {16'h0, IPIN, m_line};
      default: d = 32'h0;
    endcase
    d = d >> (8 * o[1:0]);
    if (s == 1) d &= 32'hFF;
    else if (s == 2) d &= 32'hFFFF;
    return d;
  endfunction

  task automatic model_wr(logic [7:0] o, logic [2:0] s, logic [31:0] wd);
    if (s == 1) begin
      if (o == 8'h0C) m_cls = wd[7:0];
      if (o == 8'h0D) m_lat = wd[7:0];
      if (o == 8'h3C) m_line = wd[7:0];
    end else if (s == 2) begin
      if (o == 8'h04) m_cmd = wd[15:0];
      if (o == 8'h0C) m_cls = wd[7:0];
    end else begin
      if (o == 8'h04) m_cmd = wd[15:0];
      if (o == 8'h30) m_rom = (wd == 32'hFFFFFFFE) ? 32'hFFFFFFFF : wd;
      if (o >= 8'h10 && o <= 8'h24) begin
        int i = (o - 8'h10) / 4;
        logic [31:0] tm = m_bar[i][0] ? 32'h3 : 32'hF;
        if (sz_of(i) != 0) begin
          if (wd == 32'hFFFFFFFF) m_bar[i] = (~(sz_of(i) - 1) & ~tm) | (m_bar[i] & tm);
          else begin
            m_bar[i] = (wd & ~tm) | (m_bar[i] & tm);
            if ((wd & ~tm) != 0) begin
              m_base[i] = wd & ~tm & ~(sz_of(i) - 1);
              m_vld[i] = 1'b1;
            end
          end
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic acc(logic [7:0] o, logic [2:0] s, bit w, logic [31:0] wd);
    bit e;
    @(negedge clk);
    acc_en = 1'b1; acc_off = o; acc_size = s; acc_wr = w; acc_wdata = wd;
    #2;
    s_rd = acc_rdata; s_err = acc_err;
    e = exp_err(o, s, w);
    chk((w && s == 1) ? "R6 err" : "R3 err", {31'h0, s_err}, {31'h0, e});
    if (!w) chk(e ? "R3 rdata" : "R2 rdata", s_rd, e ? 32'h0 : exp_rd(o, s));
    if (w && !e) model_wr(o, s, wd);
    @(posedge clk); #1;
    acc_en = 1'b0;
    chk("R10 valid", {26'h0, bar_valid}, {26'h0, m_vld});
    for (int i = 0; i < 6; i++) chk("R10 base", bar_base[32*i +: 32], m_base[i]);
  endtask

  task automatic rd(logic [7:0] o, logic [2:0] s); acc(o, s, 1'b0, 32'h0); endtask
  task automatic wr(logic [7:0] o, logic [2:0] s, logic [31:0] d); acc(o, s, 1'b1, d); endtask

  bit done = 1'b0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    model_reset();
    repeat (3) @(posedge clk);
    #1 chk("R1 reset valid", {26'h0, bar_valid}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    rd(8'h00, 4); chk("R1 id", s_rd, 32'h0B17CAFE);
    rd(8'h08, 4); chk("R1 class", s_rd, 32'h02000003);
    rd(8'h3C, 4); chk("R1 irq", s_rd, 32'h00000100);
    rd(8'h0E, 1); chk("R1 hdr", s_rd, 32'h0);
    rd(8'h01, 1); chk("R2 byte", s_rd, 32'hCA);
    rd(8'h02, 2); chk("R2 half", s_rd, 32'h0B17);

    rd(8'h00, 3); chk("R3 size", {31'h0, s_err}, 1);
    rd(8'h40, 4); chk("R3 high", {31'h0, s_err}, 1);
    rd(8'h02, 4); chk("R3 misalign", {31'h0, s_err}, 1);
    wr(8'h11, 4, 32'h0000_8000); chk("R3 write", {31'h0, s_err}, 1);
    rd(8'h10, 4); chk("R3 unchanged", s_rd, 32'h8);

    wr(8'h3C, 1, 32'h0A); rd(8'h3C, 1); chk("R4 line", s_rd, 32'h0A);
    wr(8'h0D, 1, 32'h40); rd(8'h0D, 1); chk("R4 lat", s_rd, 32'h40);
    wr(8'h3D, 1, 32'hFF); chk("R5 noerr", {31'h0, s_err}, 0);
    rd(8'h3C, 4); chk("R5 pin", s_rd, 32'h0000010A);
    wr(8'h09, 1, 32'h77); rd(8'h08, 4); chk("R5 class", s_rd, 32'h02000003);
    wr(8'h00, 1, 32'h55); chk("R6 err", {31'h0, s_err}, 1);
    rd(8'h00, 4); chk("R6 id", s_rd, 32'h0B17CAFE);

    wr(8'h04, 2, 32'hBEEF); rd(8'h04, 4); chk("R7 cmd", s_rd, 32'h0000BEEF);
    wr(8'h06, 2, 32'hFFFF); rd(8'h04, 4); chk("R7 status", s_rd, 32'h0000BEEF);
    wr(8'h00, 2, 32'h1); chk("R7 err", {31'h0, s_err}, 1);
    wr(8'h2C, 4, 32'h12345678); chk("R7 ign", {31'h0, s_err}, 0);
    rd(8'h2C, 4); chk("R7 ign rd", s_rd, 32'h0);

    wr(8'h10, 4, 32'hFFFFFFFF); rd(8'h10, 4); chk("R8 bar0", s_rd, 32'hFFFFF008);
    wr(8'h14, 4, 32'hFFFFFFFF); rd(8'h14, 4); chk("R8 bar1", s_rd, 32'hFFFFFF01);
    wr(8'h1C, 4, 32'hFFFFFFFF); rd(8'h1C, 4); chk("R8 bar3", s_rd, 32'hFFFFFFF0);
    wr(8'h20, 4, 32'hFFFFFFFF); rd(8'h20, 4); chk("R8 bar4", s_rd, 32'hFFFFFFFD);
    wr(8'h24, 4, 32'hFFFFFFFF); rd(8'h24, 4); chk("R8 bar5", s_rd, 32'hFFF00000);

    wr(8'h10, 4, 32'h12345671); rd(8'h10, 4); chk("R9 bar0", s_rd, 32'h12345678);
    chk("R10 base0", bar_base[31:0], 32'h12345000);
    wr(8'h14, 4, 32'h0000C003); rd(8'h14, 4); chk("R9 bar1", s_rd, 32'h0000C001);
    chk("R10 base1", bar_base[63:32], 32'h0000C000);
    wr(8'h1C, 4, 32'h0000000F); chk("R10 novalid", {31'h0, bar_valid[3]}, 0);

    rd(8'h18, 4); chk("R11 rd", s_rd, 32'h0);
    wr(8'h18, 4, 32'h12340000); rd(8'h18, 4); chk("R11 wr", s_rd, 32'h0);
    chk("R11 valid", {31'h0, bar_valid[2]}, 0);

    wr(8'h30, 4, 32'hFFFFFFFE); rd(8'h30, 4); chk("R12 size", s_rd, 32'hFFFFFFFF);
    wr(8'h30, 4, 32'h000F0001); rd(8'h30, 4); chk("R12 store", s_rd, 32'h000F0001);

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] o;
      logic [2:0] s;
      logic [31:0] d;
      int r = $urandom % 16;
      o = 8'($urandom % 72);
      if (r < 6) o = 8'h10 + 8'(4 * ($urandom % 6));
      s = 3'($urandom % 8);
      if (r < 11) s = 3'd4;
      else if (s > 4) s = 3'(1 + $urandom % 2);
      d = $urandom;
      if (r < 3) d = 32'hFFFFFFFF;
      else if (r == 3) d = 32'hFFFFFFFE;
      else if (r == 4) o = 8'h30;
      acc(o, s, ($urandom % 2) == 1, d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule